// File: doc/BRIEF.md
# Logarithmic Cross-Pattern Motion Search Controller

This block steers a block-matching motion search over a square window of ±D pixels around the origin. It computes no match costs itself. For each candidate displacement it asks an external cost engine through a request/acknowledge handshake and receives a sum of absolute differences (SAD). One search pass evaluates a plus-shaped group of points: the current centre and the four points one step away along each axis. The search then moves to the cheapest of these points.

The step starts at D/4. It is cut in half only when the centre of a pass stays the cheapest point, or when the winning point lies on the edge of the window. Otherwise the next pass keeps the same step around the new winner, so the number of passes depends on the picture content. The search ends after a pass at step 1 in which the centre stays best or the winner touches the edge. A pass counter aborts a search that has not converged after ITER_MAX passes, by default 4·D, and reports the best point found so far.

A host pulses `start`, serves cost requests, and collects the motion vector and its SAD when `done` pulses.

Top module: `log_cross_search`

## Requirements
- R1: After reset, `busy`, `done`, `aborted` and `cost_req` are 0, and `mv_u`, `mv_v` and `min_sad` are 0.
- R2: A `start` pulse while idle raises `cost_req` on the next cycle, with offset (0,0). A `start` while `busy` is 1 has no effect on the search or its result.
- R3: After the centre, each pass requests its neighbours in the fixed order (u+s,v), (u−s,v), (u,v+s), (u,v−s), where s is the current step. The first step is D/4, so with D=8 the second request of a search is (2,0).
- R4: A neighbour with |u|>D or |v|>D is skipped and never appears on `cost_u`/`cost_v`. Requests always lie inside the window.
- R5: `cost_req` stays high with stable offsets until `cost_ack` is sampled high. `cost_sad` is taken in that cycle, and `cost_req` is low in the next cycle.
- R6: A neighbour replaces the current best only if its SAD is strictly lower. On equal cost the centre wins, and among equal neighbours the earlier one in the R3 order wins.
- R7: The step is halved after a pass whose winner is the centre or lies on the window edge (|u|=D or |v|=D). Otherwise the step is kept and the next pass is centred on the winner.
- R8: The search ends after a step-1 pass whose winner is the centre or lies on the edge. `mv_u`, `mv_v` and `min_sad` then give the winning offset and its SAD.
- R9: `done` is high for exactly one cycle at the end of a search, with `busy` low in that cycle. The results hold their values until the next accepted `start`.
- R10: If ITER_MAX passes complete without termination, the search stops with `done` and `aborted` high and reports the best point so far. `aborted` is 0 for a search that ends normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (accepted only while idle) |
| cost_req | output | 1 | Cost request to the external engine |
| cost_u | output | VW | Signed horizontal offset of the requested candidate |
| cost_v | output | VW | Signed vertical offset of the requested candidate |
| cost_ack | input | 1 | Cost engine acknowledge, SAD valid |
| cost_sad | input | SADW | SAD of the requested candidate |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| aborted | output | 1 | Last search stopped on the pass limit |
| mv_u | output | VW | Signed horizontal motion vector |
| mv_v | output | VW | Signed vertical motion vector |
| min_sad | output | SADW | SAD at the motion vector |

## Verification
A wrong step value, a wrong centre or a wrong candidate index shows up on `cost_u`/`cost_v` at the next request. The bench therefore logs every offset of a search and compares its positions against hand-traced walks, including one where a halving happens only after the third pass. A wrong halving or termination decision changes the total request count and the final vector, which are checked within the same search. Tie handling and edge skipping are exercised by cost surfaces with equal minima and by targets that lie on each window edge.

// File: rtl/log_cross_search.sv
module log_cross_search #(
  parameter int D        = 8,
  parameter int SADW     = 32,
  parameter int ITER_MAX = 4 * D,
  localparam int VW      = $clog2(D + 1) + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic                   cost_req,
  output logic signed [VW-1:0]   cost_u,
  output logic signed [VW-1:0]   cost_v,
  input  logic                   cost_ack,
  input  logic [SADW-1:0]        cost_sad,
  output logic                   busy,
  output logic                   done,
  output logic                   aborted,
  output logic signed [VW-1:0]   mv_u,
  output logic signed [VW-1:0]   mv_v,
  output logic [SADW-1:0]        min_sad
);

  localparam int IW = $clog2(ITER_MAX + 1);
  localparam logic signed [VW-1:0] DL    = VW'(D);
  localparam logic signed [VW-1:0] STEP0 = VW'(D / 4);
  localparam logic signed [VW-1:0] ONE   = VW'(1);

  typedef enum logic [1:0] {S_IDLE, S_CHK, S_REQ, S_END} st_t;

  st_t                  st;
  logic signed [VW-1:0] cu, cv, bu, bv, step, nu, nv;
  logic [2:0]           k;
  logic [IW-1:0]        iter, iter_n;
  logic [SADW-1:0]      best;
  logic                 done_q, abort_q;
  logic                 in_win, moved, edge_hit, shrink;

  always_comb begin
    nu = cu;
    nv = cv;
    case (k)
      3'd1:    nu = cu + step;
      3'd2:    nu = cu - step;
      3'd3:    nv = cv + step;
      3'd4:    nv = cv - step;
      default: ;
    endcase
  end

  assign in_win   = (nu >= -DL) && (nu <= DL) && (nv >= -DL) && (nv <= DL);
  assign moved    = (bu != cu) || (bv != cv);
  assign edge_hit = (bu == DL) || (bu == -DL) || (bv == DL) || (bv == -DL);
  assign shrink   = !moved || edge_hit;
  assign iter_n   = iter + 1'b1;

  assign cost_req = (st == S_REQ);
  assign cost_u   = nu;
  assign cost_v   = nv;
  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign aborted  = abort_q;
  assign mv_u     = bu;
  assign mv_v     = bv;
  assign min_sad  = best;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cu      <= '0;
      cv      <= '0;
      bu      <= '0;
      bv      <= '0;
      step    <= '0;
      k       <= '0;
      iter    <= '0;
      best    <= '0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cu      <= '0;
          cv      <= '0;
          bu      <= '0;
          bv      <= '0;
          step    <= STEP0;
          k       <= '0;
          iter    <= '0;
          abort_q <= 1'b0;
          st      <= S_REQ;
        end
        S_CHK: begin
          if (in_win)        st <= S_REQ;
          else if (k == 3'd4) st <= S_END;
          else               k  <= k + 3'd1;
        end
        S_REQ: if (cost_ack) begin
          if (k == 3'd0 || cost_sad < best) begin
            best <= cost_sad;
            bu   <= nu;
            bv   <= nv;
          end
          if (k == 3'd4) st <= S_END;
          else begin
            k  <= k + 3'd1;
            st <= S_CHK;
          end
        end
        S_END: begin
          if (shrink && step == ONE) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (iter_n == IW'(ITER_MAX)) begin
            done_q  <= 1'b1;
            abort_q <= 1'b1;
            st      <= S_IDLE;
          end else begin
            if (shrink) step <= step >>> 1;
            cu   <= bu;
            cv   <= bv;
            k    <= 3'd1;
            iter <= iter_n;
            st   <= S_CHK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_START_CENTRE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (cost_req && cost_u == '0 && cost_v == '0)); // R2

  AST_REQ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cost_req |-> (cost_u >= -DL && cost_u <= DL && cost_v >= -DL && cost_v <= DL)); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cost_req && !cost_ack) |=> (cost_req && $stable(cost_u) && $stable(cost_v))); // R5

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cost_req && cost_ack) |=> !cost_req); // R5

  AST_STEP_NONINC: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (step <= $past(step) && step >= ONE)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && !$past(start)) |-> ($stable(mv_u) && $stable(mv_v) && $stable(min_sad))); // R9

  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    iter < IW'(ITER_MAX)); // R10

endmodule

// File: tb/tb_log_cross_search.sv
module tb_log_cross_search;
  localparam int D  = 8;
  localparam int VW = $clog2(D + 1) + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                 start = 1'b0, ack = 1'b0;
  logic [31:0]          sad = '0;
  logic                 req, busy, done, abrt;
  logic signed [VW-1:0] cu, cv, mu, mv;
  logic [31:0]          msad;

  logic                 l_start = 1'b0, l_ack = 1'b0;
  logic [31:0]          l_sad = '0;
  logic                 l_req, l_busy, l_done, l_abrt;
  logic signed [VW-1:0] l_cu, l_cv, l_mu, l_mv;
  logic [31:0]          l_msad;

  log_cross_search #(.D(D)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cost_req(req), .cost_u(cu), .cost_v(cv),
    .cost_ack(ack), .cost_sad(sad), .busy(busy), .done(done), .aborted(abrt),
    .mv_u(mu), .mv_v(mv), .min_sad(msad));

  log_cross_search #(.D(D), .ITER_MAX(2)) dut_lim (
    .clk(clk), .rst_n(rst_n), .start(l_start), .cost_req(l_req), .cost_u(l_cu), .cost_v(l_cv),
    .cost_ack(l_ack), .cost_sad(l_sad), .busy(l_busy), .done(l_done), .aborted(l_abrt),
    .mv_u(l_mu), .mv_v(l_mv), .min_sad(l_msad));

  int checks = 0, errors = 0;
  int mode = 0, tu = 0, tv = 0;
  int nlog = 0, oow = 0;
  int logu [64];
  int logv [64];

  function automatic int iabs(int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic int cost(int u, int v);
    case (mode)
      1: return 50;
      2: return ((u == 2 && v == 0) || (u == 0 && v == -2)) ? 90 : 100;
      3: return ((u == -2 && v == 0) || (u == 0 && v == 2)) ? 90 : 100;
      default: return 100 + 3 * iabs(u - tu) + 5 * iabs(v - tv);
    endcase
  endfunction

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (req && !ack) begin
      if (nlog < 64) begin
        logu[nlog] = int'(cu);
        logv[nlog] = int'(cv);
      end
      nlog++;
      if (iabs(int'(cu)) > D || iabs(int'(cv)) > D) oow++;
      ack = 1'b1;
      sad = 32'(cost(int'(cu), int'(cv)));
    end else ack = 1'b0;
  end

  initial forever begin
    @(negedge clk);
    if (l_req && !l_ack) begin
      l_ack = 1'b1;
      l_sad = 32'(cost(int'(l_cu), int'(l_cv)));
    end else l_ack = 1'b0;
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic run(int m, int x, int y, int extra, output bit ok);
    mode = m; tu = x; tv = y; nlog = 0; oow = 0; ok = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      if (c == extra) start = 1'b1;
      else start = 1'b0;
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  // mode, tu, tv, exp_u, exp_v, exp_sad, exp_requests
  localparam int NV = 8;
  localparam int TBL [NV][7] = '{
    '{0,  3, -2,  3, -2, 100, 21},
    '{0,  8,  0,  8,  0, 100, 20},
    '{0,  0,  0,  0,  0, 100,  9},
    '{1,  0,  0,  0,  0,  50,  9},
    '{2,  0,  0,  2,  0,  90, 13},
    '{3,  0,  0, -2,  0,  90, 13},
    '{0,  8,  1,  8,  1, 100, 20},
    '{0,  0, -8,  0, -8, 100, 20}
  };

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && abrt == 0, "R1", "busy/done/aborted after reset", {busy, done, abrt}, 0);
    chk(req == 0, "R1", "cost_req after reset", req, 0);
    chk(mu == 0 && mv == 0 && msad == 0, "R1", "results after reset", int'(msad), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run(TBL[i][0], TBL[i][1], TBL[i][2], -1, ok);
      chk(ok, "R8", $sformatf("vec %0d finished", i), ok, 1);
      chk(!busy, "R9", $sformatf("vec %0d busy at done", i), busy, 0);
      chk(int'(mu) == TBL[i][3] && int'(mv) == TBL[i][4], "R8",
          $sformatf("vec %0d mv_u*100+mv_v", i), int'(mu) * 100 + int'(mv), TBL[i][3] * 100 + TBL[i][4]);
      chk(int'(msad) == TBL[i][5], (i == 3 || i == 4 || i == 5) ? "R6" : "R8",
          $sformatf("vec %0d min_sad", i), int'(msad), TBL[i][5]);
      chk(nlog == TBL[i][6], "R7", $sformatf("vec %0d request count", i), nlog, TBL[i][6]);
      chk(oow == 0, "R4", $sformatf("vec %0d out-of-window requests", i), oow, 0);
      chk(logu[0] == 0 && logv[0] == 0, "R2", $sformatf("vec %0d first request", i), logu[0] * 100 + logv[0], 0);
      chk(abrt == 0, "R10", $sformatf("vec %0d aborted", i), abrt, 0);
      @(negedge clk);
      chk(done == 0, "R9", $sformatf("vec %0d done width", i), done, 0);
      repeat (3) @(negedge clk);
      chk(int'(mu) == TBL[i][3] && int'(mv) == TBL[i][4] && int'(msad) == TBL[i][5], "R9",
          $sformatf("vec %0d results held", i), int'(msad), TBL[i][5]);
    end

    // R2: start during a search is ignored; R3/R7: request order and halving point
    run(0, 3, -2, 10, ok);
    chk(ok && int'(mu) == 3 && int'(mv) == -2, "R2", "result with extra start", int'(mu) * 100 + int'(mv), 300 - 2);
    chk(nlog == 21, "R2", "request count with extra start", nlog, 21);
    chk(logu[1] == 2 && logv[1] == 0, "R3", "request 1 (+x at D/4)", logu[1] * 100 + logv[1], 200);
    chk(logu[2] == -2 && logv[2] == 0, "R3", "request 2 (-x)", logu[2] * 100 + logv[2], -200);
    chk(logu[3] == 0 && logv[3] == 2, "R3", "request 3 (+y)", logu[3] * 100 + logv[3], 2);
    chk(logu[4] == 0 && logv[4] == -2, "R3", "request 4 (-y)", logu[4] * 100 + logv[4], -2);
    chk(logu[9] == 4 && logv[9] == -2, "R7", "pass 3 keeps step 2", logu[9] * 100 + logv[9], 400 - 2);
    chk(logu[13] == 3 && logv[13] == -2, "R7", "pass 4 halved to step 1", logu[13] * 100 + logv[13], 300 - 2);
    chk(logu[12] == 2 && logv[12] == -4, "R6", "tie at (4,-2) keeps centre", logu[12] * 100 + logv[12], 200 - 4);

    // R4: edge walk never requests beyond the window
    run(0, -8, 0, -1, ok);
    chk(oow == 0 && int'(mu) == -8 && int'(mv) == 0, "R4", "left edge result", int'(mu), -8);
    chk(nlog == 20, "R4", "left edge request count", nlog, 20);

    // R10: pass limit on the second instance
    mode = 0; tu = 6; tv = 0;
    @(negedge clk); l_start = 1'b1;
    @(negedge clk); l_start = 1'b0;
    ok = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      if (l_done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    chk(ok && l_abrt == 1, "R10", "abort flag", l_abrt, 1);
    chk(int'(l_mu) == 4 && int'(l_mv) == 0 && int'(l_msad) == 106, "R10", "best so far sad", int'(l_msad), 106);

    // R1: reset in mid-search
    mode = 0; tu = 3; tv = -2;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy == 0 && req == 0 && done == 0 && mu == 0 && msad == 0, "R1", "reset during search", {busy, req}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule